// File: doc/BRIEF.md
# Multi-Level Address Translation Walker

This block turns a 64-bit virtual address into a real address by walking a tree of in-memory translation tables. The tree has up to five levels: three region levels (first, second and third), a segment level and a page level. A space descriptor supplied with each request gives the table origin, the level where the walk begins, the length of the first table, a private-space flag and a real-space flag. The walker fetches one 64-bit entry per level over a simple request/response memory port, checks it, and either moves down to the next table, finishes with a real address plus write and execute permissions, or stops with an exception code.

Large frames can cut the walk short. When the matching feature enables are set, a third-level region entry or a segment entry may map a whole frame directly. A separate enable controls whether execute-protection bits in the entries take effect. Checks on the final access and storage keys belong to the surrounding logic.

The control is a five-state machine. ST_IDLE waits for `start`. From it, the transition real-hit goes to ST_DONE, start-reject goes to ST_FAULT, and start-walk goes to ST_ISSUE. ST_ISSUE raises `mem_req` for one cycle, and the transition issue-sent goes to ST_WAIT. ST_WAIT holds until `mem_rsp_valid`. Then descend goes back to ST_ISSUE, leaf goes to ST_DONE, and entry-fault goes to ST_FAULT. ST_DONE and ST_FAULT each last one cycle, and the transition retire goes to ST_IDLE.

Top module: `xlate_walker`

## Requirements
- R1: With `desc_real` high, the request completes with `done` one cycle after `start`. `res_addr` equals `va`, both permissions are 1, and no memory read is made.
- R2: `desc_type` selects the first level: 3 = region-1, 2 = region-2, 1 = region-3, 0 = segment. Virtual index fields for levels above the first must be zero, or the walk faults with code 3 and makes no read. The index fields are: region-1 va[63:53], region-2 va[52:42], region-3 va[41:31], segment va[30:20], page va[19:12].
- R3: If the top two bits of the first index exceed `desc_tlen`, the walk faults with no read. The code names the first level: 4 region-1, 5 region-2, 6 region-3, 7 segment, 8 page.
- R4: Each entry address is a table origin (low 12 bits cleared; low 11 bits for page tables) plus index × 8. The response carries the byte at address+k in `mem_rsp_data[8k+7:8k]`, and the entry value is read most-significant byte first. A region entry holds its next origin in [63:12]. A segment entry holds its next origin in [63:11]. A page entry holds its frame in [63:12], and the result is that frame ORed with va[11:0].
- R5: A read answered with `mem_rsp_err` faults with code 1.
- R6: An entry with its invalid bit set faults with its own level's code. The invalid bit is bit 5 in region and segment entries and bit 10 in page entries.
- R7: A table-type field [3:2] that does not match the level faults with code 2. The expected value is 3 for region-1, 2 for region-2, 1 for region-3 and 0 for segment.
- R8: In a region entry, the top two bits of the next index must lie between the entry's offset field [7:6] and its length field [1:0]. Otherwise the walk faults with the next level's code.
- R9: Bit 9 clears write permission in segment and page entries, and in region entries only when `en_lf1` is high.
- R10: With `en_lf2` high, a region-3 entry with bit 10 set ends the walk with `{entry[63:31], va[30:0]}`. In that case bit 8 clears execute permission when `en_xprot` is high.
- R11: With `en_lf1` high, a segment entry with bit 10 set ends the walk with `{entry[63:20], va[19:0]}`, and bit 8 clears execute permission when `en_xprot` is high. A segment entry with bit 4 set faults with code 2 when `desc_private` is high.
- R12: A page entry with bit 8 set faults with code 2. Bit 7 clears execute permission only when `en_xprot` is high.
- R13: At most one read is outstanding, and `mem_req` lasts one cycle per read. `busy` is high from the cycle after `start` through the single-cycle `done` or `fault` pulse. That pulse comes one cycle after the last response, or one cycle after `start` when no read is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a translation (sampled while idle) |
| va | input | 64 | Virtual address |
| desc_origin | input | 64 | First table origin |
| desc_type | input | 2 | First level selector |
| desc_tlen | input | 2 | First table length |
| desc_private | input | 1 | Private-space flag |
| desc_real | input | 1 | Real-space flag: no translation |
| en_lf1 | input | 1 | Segment large frames and region protection |
| en_lf2 | input | 1 | Region-3 large frames |
| en_xprot | input | 1 | Execute protection enable |
| mem_req | output | 1 | Entry read request pulse |
| mem_addr | output | 64 | Entry address |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 64 | Entry bytes, byte k in lane k |
| mem_rsp_err | input | 1 | Read failed |
| busy | output | 1 | Translation in progress |
| done | output | 1 | Success pulse |
| fault | output | 1 | Exception pulse |
| fault_code | output | 4 | Exception code, valid with fault |
| res_addr | output | 64 | Real address, valid with done |
| res_w | output | 1 | Write permitted, valid with done |
| res_x | output | 1 | Execute permitted, valid with done |

## Verification
Every result has a fixed due cycle. A request that needs no read finishes one cycle after `start`. With the bench memory answering in the cycle after each request, a walk that makes n reads finishes 1 + 2n cycles after `start`. The driver stamps each expected item with its due cycle and its expected read count. The monitor compares them with the cycle and read count it observes when `done` or `fault` appears, then checks the payload, sampling on the falling edge.

// File: rtl/walk_pkg.sv
package walk_pkg;
    localparam int VA_W    = 64;
    localparam int ENT_W   = 64;
    localparam int IDX_W   = 11;
    localparam int CODE_W  = 4;
    localparam int ENT_B   = ENT_W / 8;

    typedef enum logic [2:0] {
        LV_PAGE = 3'd0,
        LV_SEG  = 3'd1,
        LV_R3   = 3'd2,
        LV_R2   = 3'd3,
        LV_R1   = 3'd4
    } level_t;

    typedef enum logic [CODE_W-1:0] {
        EX_NONE  = 4'd0,
        EX_ADDR  = 4'd1,
        EX_SPEC  = 4'd2,
        EX_SPACE = 4'd3,
        EX_R1    = 4'd4,
        EX_R2    = 4'd5,
        EX_R3    = 4'd6,
        EX_SEG   = 4'd7,
        EX_PAGE  = 4'd8
    } exc_t;

    typedef enum logic [1:0] {
        ACT_NEXT,
        ACT_LEAF,
        ACT_FAULT
    } act_t;

    function automatic logic [IDX_W-1:0] idx_of(level_t lv, logic [VA_W-1:0] v);
        logic [IDX_W-1:0] r;
        case (lv)
            LV_R1:   r = v[63:53];
            LV_R2:   r = v[52:42];
            LV_R3:   r = v[41:31];
            LV_SEG:  r = v[30:20];
            default: r = {3'b000, v[19:12]};
        endcase
        return r;
    endfunction

    function automatic exc_t trans_exc(level_t lv);
        exc_t e;
        case (lv)
            LV_R1:   e = EX_R1;
            LV_R2:   e = EX_R2;
            LV_R3:   e = EX_R3;
            LV_SEG:  e = EX_SEG;
            default: e = EX_PAGE;
        endcase
        return e;
    endfunction
endpackage

// File: rtl/walk_byteswap.sv
module walk_byteswap #(
    parameter int BYTES = 8
) (
    input  logic [8*BYTES-1:0] lanes,
    output logic [8*BYTES-1:0] value
);
    for (genvar k = 0; k < BYTES; k++) begin : g_lane
        assign value[8*(BYTES-1-k) +: 8] = lanes[8*k +: 8];
    end
endmodule

// File: rtl/walk_start_check.sv
module walk_start_check
    import walk_pkg::*;
(
    input  logic [VA_W-1:0] va,
    input  logic [1:0]      dtype,
    input  logic [1:0]      tlen,
    input  logic [VA_W-1:0] origin,
    output level_t          first_lv,
    output exc_t            code,
    output logic [VA_W-1:0] first_addr
);
    logic [6:0]       sh;
    logic [VA_W-1:0]  upper;
    logic [IDX_W-1:0] idx;
    logic             unused_org;

    assign first_lv   = level_t'({1'b0, dtype} + 3'd1);
    assign sh         = 7'd31 + 7'd11 * {5'b0, dtype};
    assign upper      = va >> sh;
    assign idx        = idx_of(first_lv, va);
    assign first_addr = {origin[VA_W-1:12], 12'b0} + {50'b0, idx, 3'b000};
    assign unused_org = ^origin[11:0];

    always_comb begin
        if (upper != '0)
            code = EX_SPACE;
        else if (idx[IDX_W-1:IDX_W-2] > tlen)
            code = trans_exc(first_lv);
        else
            code = EX_NONE;
    end
endmodule

// File: rtl/walk_entry_decode.sv
module walk_entry_decode
    import walk_pkg::*;
(
    input  level_t           lv,
    input  logic [ENT_W-1:0] ent,
    input  logic [VA_W-1:0]  va,
    input  logic             priv,
    input  logic             lf1,
    input  logic             lf2,
    input  logic             xprot,
    output act_t             act,
    output exc_t             code,
    output level_t           next_lv,
    output logic [VA_W-1:0]  next_addr,
    output logic [VA_W-1:0]  leaf_addr,
    output logic             clr_w,
    output logic             clr_x
);
    level_t           lower;
    logic [IDX_W-1:0] nidx;
    logic [1:0]       nhi;
    logic [1:0]       tt_want;
    logic             unused_ent;

    assign lower      = (lv == LV_PAGE) ? LV_PAGE : level_t'(lv - 3'd1);
    assign nidx       = idx_of(lower, va);
    assign nhi        = nidx[IDX_W-1:IDX_W-2];
    assign tt_want    = 2'(lv - 3'd1);
    assign unused_ent = ent[11];

    always_comb begin
        act       = ACT_FAULT;
        code      = EX_SPEC;
        next_lv   = LV_PAGE;
        next_addr = '0;
        leaf_addr = '0;
        clr_w     = 1'b0;
        clr_x     = 1'b0;
        unique case (lv)
            LV_R1, LV_R2, LV_R3: begin
                clr_w = lf1 & ent[9];
                if (ent[5]) begin
                    code = trans_exc(lv);
                end else if (ent[3:2] != tt_want) begin
                    code = EX_SPEC;
                end else if (lv == LV_R3 && lf2 && ent[10]) begin
                    act       = ACT_LEAF;
                    code      = EX_NONE;
                    clr_x     = xprot & ent[8];
                    leaf_addr = {ent[63:31], va[30:0]};
                end else if (nhi < ent[7:6] || nhi > ent[1:0]) begin
                    code = trans_exc(lower);
                end else begin
                    act       = ACT_NEXT;
                    code      = EX_NONE;
                    next_lv   = lower;
                    next_addr = {ent[63:12], 12'b0} + {50'b0, nidx, 3'b000};
                end
            end
            LV_SEG: begin
                clr_w = ent[9];
                if (ent[5]) begin
                    code = EX_SEG;
                end else if (ent[3:2] != 2'b00) begin
                    code = EX_SPEC;
                end else if (ent[4] && priv) begin
                    code = EX_SPEC;
                end else if (lf1 && ent[10]) begin
                    act       = ACT_LEAF;
                    code      = EX_NONE;
                    clr_x     = xprot & ent[8];
                    leaf_addr = {ent[63:20], va[19:0]};
                end else begin
                    act       = ACT_NEXT;
                    code      = EX_NONE;
                    next_lv   = LV_PAGE;
                    next_addr = {ent[63:11], 11'b0} + {53'b0, va[19:12], 3'b000};
                end
            end
            LV_PAGE: begin
                clr_w = ent[9];
                clr_x = xprot & ent[7];
                if (ent[10]) begin
                    code = EX_PAGE;
                end else if (ent[8]) begin
                    code = EX_SPEC;
                end else begin
                    act       = ACT_LEAF;
                    code      = EX_NONE;
                    leaf_addr = {ent[63:12], va[11:0]};
                end
            end
            default: begin
                code = EX_SPEC;
            end
        endcase
    end
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
    import walk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [63:0] va,
    input  logic [63:0] desc_origin,
    input  logic [1:0]  desc_type,
    input  logic [1:0]  desc_tlen,
    input  logic        desc_private,
    input  logic        desc_real,
    input  logic        en_lf1,
    input  logic        en_lf2,
    input  logic        en_xprot,
    output logic        mem_req,
    output logic [63:0] mem_addr,
    input  logic        mem_rsp_valid,
    input  logic [63:0] mem_rsp_data,
    input  logic        mem_rsp_err,
    output logic        busy,
    output logic        done,
    output logic        fault,
    output logic [3:0]  fault_code,
    output logic [63:0] res_addr,
    output logic        res_w,
    output logic        res_x
);
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE,
        ST_FAULT
    } state_t;

    state_t           state, state_d;
    logic [VA_W-1:0]  va_q, addr_q, res_q;
    level_t           lv_q;
    exc_t             code_q;
    logic             priv_q, lf1_q, lf2_q, xp_q, w_q, x_q;

    level_t           sc_lv;
    exc_t             sc_code;
    logic [VA_W-1:0]  sc_addr;
    logic [ENT_W-1:0] ent;
    act_t             dc_act;
    exc_t             dc_code;
    level_t           dc_lv;
    logic [VA_W-1:0]  dc_next, dc_leaf;
    logic             dc_clr_w, dc_clr_x;

    walk_start_check u_start (
        .va(va), .dtype(desc_type), .tlen(desc_tlen), .origin(desc_origin),
        .first_lv(sc_lv), .code(sc_code), .first_addr(sc_addr)
    );

    walk_byteswap #(.BYTES(ENT_B)) u_swap (
        .lanes(mem_rsp_data), .value(ent)
    );

    walk_entry_decode u_dec (
        .lv(lv_q), .ent(ent), .va(va_q), .priv(priv_q),
        .lf1(lf1_q), .lf2(lf2_q), .xprot(xp_q),
        .act(dc_act), .code(dc_code), .next_lv(dc_lv),
        .next_addr(dc_next), .leaf_addr(dc_leaf),
        .clr_w(dc_clr_w), .clr_x(dc_clr_x)
    );

    // next-state selection
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (desc_real)              state_d = ST_DONE;   // real-hit
                    else if (sc_code != EX_NONE) state_d = ST_FAULT; // start-reject
                    else                        state_d = ST_ISSUE;  // start-walk
                end
            end
            ST_ISSUE: state_d = ST_WAIT;                             // issue-sent
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_err)             state_d = ST_FAULT;
                    else if (dc_act == ACT_NEXT) state_d = ST_ISSUE; // descend
                    else if (dc_act == ACT_LEAF) state_d = ST_DONE;  // leaf
                    else                         state_d = ST_FAULT; // entry-fault
                end
            end
            ST_DONE, ST_FAULT: state_d = ST_IDLE;                    // retire
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and walk context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            va_q   <= '0;
            addr_q <= '0;
            res_q  <= '0;
            lv_q   <= LV_PAGE;
            code_q <= EX_NONE;
            priv_q <= 1'b0;
            lf1_q  <= 1'b0;
            lf2_q  <= 1'b0;
            xp_q   <= 1'b0;
            w_q    <= 1'b0;
            x_q    <= 1'b0;
        end else begin
            state <= state_d;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        va_q   <= va;
                        priv_q <= desc_private;
                        lf1_q  <= en_lf1;
                        lf2_q  <= en_lf2;
                        xp_q   <= en_xprot;
                        w_q    <= 1'b1;
                        x_q    <= 1'b1;
                        res_q  <= va;
                        code_q <= sc_code;
                        lv_q   <= sc_lv;
                        addr_q <= sc_addr;
                    end
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_err) begin
                            code_q <= EX_ADDR;
                        end else begin
                            if (dc_clr_w) w_q <= 1'b0;
                            if (dc_clr_x) x_q <= 1'b0;
                            code_q <= dc_code;
                            addr_q <= dc_next;
                            lv_q   <= dc_lv;
                            res_q  <= dc_leaf;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy       = (state != ST_IDLE);
        done       = (state == ST_DONE);
        fault      = (state == ST_FAULT);
        mem_req    = (state == ST_ISSUE);
        mem_addr   = addr_q;
        fault_code = code_q;
        res_addr   = res_q;
        res_w      = w_q;
        res_x      = x_q;
    end

    assert_req_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    assert_one_event_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, fault, mem_req}));
    assert_end_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |=> !busy);
    assert_req_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[2:0] == 3'b000));
    assert_real_no_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && desc_real) |=> (done && !mem_req && res_addr == $past(va)));
    assert_space_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !desc_real && desc_type == 2'd0 && va[63:31] != '0)
        |=> (fault && fault_code == 4'd3));
    assert_fault_coded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (fault_code != 4'd0));
endmodule

// File: tb/tb_xlate_walker.sv
module tb_xlate_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] va = '0, desc_origin = '0;
    logic [1:0]  desc_type = '0, desc_tlen = '0;
    logic        desc_private = 1'b0, desc_real = 1'b0;
    logic        en_lf1 = 1'b0, en_lf2 = 1'b0, en_xprot = 1'b0;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        mem_rsp_err = 1'b0;
    logic        busy, done, fault, res_w, res_x;
    logic [3:0]  fault_code;
    logic [63:0] res_addr;

    always #2 clk = ~clk;

    xlate_walker dut (.*);

    int checks = 0, failures = 0, cyc = 0, rd_cnt = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // memory model: responds in the cycle after a request
    logic [63:0] mem [logic [63:0]];
    logic        pend = 1'b0;
    logic [63:0] paddr = '0;

    function automatic logic [63:0] to_lanes(input logic [63:0] v);
        logic [63:0] r;
        for (int k = 0; k < 8; k++) r[8*k +: 8] = v[8*(7-k) +: 8];
        return r;
    endfunction

    always @(negedge clk) begin
        mem_rsp_valid <= 1'b0;
        mem_rsp_err   <= 1'b0;
        if (pend) begin
            mem_rsp_valid <= 1'b1;
            if (mem.exists(paddr)) mem_rsp_data <= to_lanes(mem[paddr]);
            else begin mem_rsp_data <= '0; mem_rsp_err <= 1'b1; end
            pend <= 1'b0;
        end
        if (mem_req) begin
            pend  <= 1'b1;
            paddr <= mem_addr;
            rd_cnt <= rd_cnt + 1;
        end
    end

    typedef struct packed {
        logic        isf;
        logic [3:0]  code;
        logic [63:0] addr;
        logic        w;
        logic        x;
        int          due;
        int          nrd;
        int          rbase;
    } exp_t;
    exp_t  q[$];
    string tq[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && (done || fault)) begin
            if (q.size() == 0) begin
                chk(1'b0, "R13", "unexpected result", 64'(done), 64'd0);
            end else begin
                exp_t e;
                string t;
                e = q.pop_front();
                t = tq.pop_front();
                chk(cyc == e.due, t, "due cycle", 64'(cyc), 64'(e.due));
                chk(rd_cnt - e.rbase == e.nrd, t, "read count", 64'(rd_cnt - e.rbase), 64'(e.nrd));
                if (e.isf)
                    chk(fault && fault_code == e.code, t, "fault code",
                        {59'(fault), fault_code, 1'b0}, {59'd1, e.code, 1'b0});
                else
                    chk(done && res_addr == e.addr && res_w == e.w && res_x == e.x, t, "result",
                        res_addr ^ {62'd0, res_w, res_x}, e.addr ^ {62'd0, e.w, e.x});
            end
        end
    end

    // driver
    task automatic run(input logic [63:0] v, input logic [63:0] org, input logic [1:0] ty,
                       input logic [1:0] tl, input logic pr, input logic rl,
                       input logic l1, input logic l2, input logic xp,
                       input bit isf, input logic [3:0] ec, input logic [63:0] ea,
                       input bit ew, input bit ex, input int nrd, input string tag);
        exp_t e;
        @(negedge clk);
        va = v; desc_origin = org; desc_type = ty; desc_tlen = tl;
        desc_private = pr; desc_real = rl; en_lf1 = l1; en_lf2 = l2; en_xprot = xp;
        start = 1'b1;
        e.isf = isf; e.code = ec; e.addr = ea; e.w = ew; e.x = ex;
        e.due = cyc + 1 + 2 * nrd; e.nrd = nrd; e.rbase = rd_cnt;
        q.push_back(e);
        tq.push_back(tag);
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
    endtask

    function automatic logic [63:0] rgn(input logic [63:0] org, input logic [1:0] tt,
                                        input logic [1:0] tf, input logic [1:0] tl);
        return {org[63:12], 12'b0} | {56'd0, tf, 1'b0, 1'b0, tt, tl};
    endfunction

    localparam logic [63:0] VAF = (64'd1 << 53) | (64'd2 << 42) | (64'd3 << 31) |
                                  (64'd4 << 20) | (64'd5 << 12) | 64'h123;
    localparam logic [63:0] A1 = 64'h10008, A2 = 64'h20010, A3 = 64'h30018,
                            AS = 64'h40020, AP = 64'h50028;
    logic [63:0] e1, e2, e3, es, ep;

    initial begin
        e1 = rgn(64'h20000, 2'd3, 2'd0, 2'd3);
        e2 = rgn(64'h30000, 2'd2, 2'd0, 2'd3);
        e3 = rgn(64'h40000, 2'd1, 2'd0, 2'd3);
        es = 64'h50000;
        ep = 64'h7777000;
        mem[A1] = e1; mem[A2] = e2; mem[A3] = e3; mem[AS] = es; mem[AP] = ep;

        repeat (3) @(negedge clk);
        // R13: reset state
        chk(!busy && !done && !fault && !mem_req, "R13", "reset outputs",
            {60'd0, busy, done, fault, mem_req}, 64'd0);
        rst_n = 1'b1;

        // R4: full five-level walk, and starts at lower levels
        run(VAF, 64'h10000, 2'd3, 2'd3, 0, 0, 0, 0, 0, 0, 0, 64'h7777123, 1, 1, 5, "R4");
        run((64'd4 << 20) | (64'd5 << 12) | 64'h45, 64'h40000, 2'd0, 2'd3, 0, 0, 0, 0, 0,
            0, 0, 64'h7777045, 1, 1, 2, "R4");
        run((64'd3 << 31) | (64'd4 << 20) | (64'd5 << 12) | 64'h9, 64'h30000, 2'd1, 2'd3,
            0, 0, 0, 0, 0, 0, 0, 64'h7777009, 1, 1, 3, "R4");
        // R1: real space
        run(64'hDEAD_BEEF_0000_1234, 64'h10000, 2'd3, 2'd3, 0, 1, 0, 0, 0,
            0, 0, 64'hDEAD_BEEF_0000_1234, 1, 1, 0, "R1");
        // R2: higher index fields non-zero
        run(VAF, 64'h40000, 2'd0, 2'd3, 0, 0, 0, 0, 0, 1, 4'd3, 0, 0, 0, 0, "R2");
        run(VAF, 64'h20000, 2'd2, 2'd3, 0, 0, 0, 0, 0, 1, 4'd3, 0, 0, 0, 0, "R2");
        // R3: first table length
        run(64'h200 << 53, 64'h10000, 2'd3, 2'd0, 0, 0, 0, 0, 0, 1, 4'd4, 0, 0, 0, 0, "R3");
        run(64'h600 << 20, 64'h40000, 2'd0, 2'd0, 0, 0, 0, 0, 0, 1, 4'd7, 0, 0, 0, 0, "R3");
        // R5: read error
        run(VAF, 64'h90000, 2'd3, 2'd3, 0, 0, 0, 0, 0, 1, 4'd1, 0, 0, 0, 1, "R5");
        // R6: invalid entries
        mem[AP] = ep | (64'd1 << 10);
        run(VAF, 64'h10000, 2'd3, 2'd3, 0, 0, 0, 0, 0, 1, 4'd8, 0, 0, 0, 5, "R6");
        mem[AP] = ep;
        mem[A2] = e2 | (64'd1 << 5);
        run(VAF, 64'h10000, 2'd3, 2'd3, 0, 0, 0, 0, 0, 1, 4'd5, 0, 0, 0, 2, "R6");
        mem[A2] = e2;
        // R7: table type mismatch
        mem[A3] = rgn(64'h40000, 2'd2, 2'd0, 2'd3);
        run(VAF, 64'h10000, 2'd3, 2'd3, 0, 0, 0, 0, 0, 1, 4'd2, 0, 0, 0, 3, "R7");
        mem[A3] = e3;
        // R8: offset and length in region entries
        mem[A1] = rgn(64'h20000, 2'd3, 2'd1, 2'd3);
        run(VAF, 64'h10000, 2'd3, 2'd3, 0, 0, 0, 0, 0, 1, 4'd5, 0, 0, 0, 1, "R8");
        mem[A1] = e1;
        mem[A3] = rgn(64'h40000, 2'd1, 2'd0, 2'd1);
        mem[64'h40000 + 64'h400 * 8] = es;
        run((VAF & ~(64'h7FF << 20)) | (64'h400 << 20), 64'h10000, 2'd3, 2'd3, 0, 0, 0, 0, 0,
            1, 4'd7, 0, 0, 0, 3, "R8");
        mem[A3] = e3;
        // R9: protection bits
        mem[A2] = e2 | (64'd1 << 9);
        run(VAF, 64'h10000, 2'd3, 2'd3, 0, 0, 0, 0, 0, 0, 0, 64'h7777123, 1, 1, 5, "R9");
        run(VAF, 64'h10000, 2'd3, 2'd3, 0, 0, 1, 0, 0, 0, 0, 64'h7777123, 0, 1, 5, "R9");
        mem[A2] = e2;
        mem[AP] = ep | (64'd1 << 9);
        run(VAF, 64'h10000, 2'd3, 2'd3, 0, 0, 0, 0, 0, 0, 0, 64'h7777123, 0, 1, 5, "R9");
        mem[AP] = ep;
        // R10: region-3 large frame
        mem[A3] = 64'h1_8000_0000 | (64'd1 << 10) | (64'd1 << 8) | (64'd1 << 2);
        run(VAF, 64'h10000, 2'd3, 2'd3, 0, 0, 0, 1, 1, 0, 0, 64'h1_8040_5123, 1, 0, 3, "R10");
        run(VAF, 64'h10000, 2'd3, 2'd3, 0, 0, 0, 1, 0, 0, 0, 64'h1_8040_5123, 1, 1, 3, "R10");
        mem[A3] = e3;
        // R11: segment large frame and common-segment check
        mem[AS] = 64'hA00000 | (64'd1 << 10);
        run(VAF, 64'h10000, 2'd3, 2'd3, 0, 0, 1, 0, 0, 0, 0, 64'hA05123, 1, 1, 4, "R11");
        mem[AS] = es | (64'd1 << 4);
        run(VAF, 64'h10000, 2'd3, 2'd3, 1, 0, 0, 0, 0, 1, 4'd2, 0, 0, 0, 4, "R11");
        run(VAF, 64'h10000, 2'd3, 2'd3, 0, 0, 0, 0, 0, 0, 0, 64'h7777123, 1, 1, 5, "R11");
        mem[AS] = es;
        // R12: page reserved and execute-protection bits
        mem[AP] = ep | (64'd1 << 8);
        run(VAF, 64'h10000, 2'd3, 2'd3, 0, 0, 0, 0, 0, 1, 4'd2, 0, 0, 0, 5, "R12");
        mem[AP] = ep | (64'd1 << 7);
        run(VAF, 64'h10000, 2'd3, 2'd3, 0, 0, 0, 0, 0, 0, 0, 64'h7777123, 1, 1, 5, "R12");
        run(VAF, 64'h10000, 2'd3, 2'd3, 0, 0, 0, 0, 1, 0, 0, 64'h7777123, 1, 0, 5, "R12");
        mem[AP] = ep;

        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R13", "missing results", 64'(q.size()), 64'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R13 watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule